// File: doc/BRIEF.md
# Chip-Select Bus Cycle Timing Generator

This block shapes the external bus cycles for a single chip-select memory area. It runs on a clock at twice the bus rate, so one clock period is half a bus cycle. Every strobe edge therefore lands on a half-cycle boundary. A 32-bit configuration register holds four fields:

- the setup delay from chip-select to strobe, in half-cycle steps from 0.5 to 3.5 bus cycles;
- the wait count for the first beat;
- a separate wait count for the second and later beats of a burst;
- a flag that makes the block ignore the external wait pin.

A requester raises `req_i` with a direction, a beat count and byte enables. The block accepts the request when it is idle. It keeps chip-select asserted for the whole transfer and drives either the read strobe or the byte write enables for each beat. After each beat it pulses `done_o` for one half-cycle. The block copies the register when it accepts an access, so a register write during a transfer only affects later accesses.

Top module: `cs_bus_timing`

## Requirements
- R1: After reset all configuration fields read as zero, and `cs_o`, `rd_o`, `we_o`, `done_o` and `busy_o` are all low.
- R2: The register layout is: bit 0 is the ignore-wait flag; bits 3:2 are the setup code; bits 6:4 are the first-beat wait count; bits 9:8 are the burst wait code. A write stores these fields. All other bits read back as zero whatever was written to them.
- R3: If `req_i` is sampled high while idle, `cs_o` rises in the next half-cycle. The strobe then rises after 2*S+1 half-cycles of chip-select, where S is the setup code (0.5, 1.5, 2.5 or 3.5 bus cycles).
- R4: The first beat keeps its strobe active for 2*(A+1) half-cycles, where A is the first-beat wait count. The strobe is `rd_o` for a read. For a write it is `we_o`, which equals the requested byte enables. Read and write strobes are never active together.
- R5: Beats 2 to N each keep the strobe active for 2*(B+1) half-cycles, where B is the burst wait code. Between two beats there is one half-cycle with the strobe low and `cs_o` still high. The beat count is `req_len_i`+1.
- R6: With the ignore flag at 0, `ext_wait_i` is sampled only in the final half-cycle of a beat's strobe, including any extension already added. Each high sample adds one bus cycle (two half-cycles) to that strobe. Values of `ext_wait_i` at any other time have no effect.
- R7: With the ignore flag at 1, `ext_wait_i` never lengthens a strobe, even when the wait count is zero.
- R8: `done_o` is high for exactly one half-cycle, in the half-cycle after each beat's strobe ends. After the last beat, `cs_o` and `busy_o` fall one half-cycle after that pulse.
- R9: The configuration in force for an access is the one present when the access is accepted. Register writes during the access do not alter its timing.
- R10: While `busy_o` is high, `req_i`, `req_write_i`, `req_len_i` and `req_be_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock (twice the bus rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register read value |
| req_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_len_i | input | LEN_W | Number of beats minus one |
| req_be_i | input | BE_W | Byte enables for writes |
| ext_wait_i | input | 1 | External wait input, active high |
| cs_o | output | 1 | Chip-select, active high |
| rd_o | output | 1 | Read strobe, active high |
| we_o | output | BE_W | Byte write enables, active high |
| done_o | output | 1 | One-half-cycle pulse when a beat completes |
| busy_o | output | 1 | Access in progress |

## Verification
The directed sweep covers every combination of setup code, burst wait code and ignore flag, using multi-beat bursts and one or two wait extensions per beat. Each of these isolates one delay field: the setup code moves only the first strobe edge, and the burst code changes only the widths of the later beats. A first-beat wait count of zero with the wait pin held high separates masking from a zero wait count. Random accesses toggle `ext_wait_i` outside the sampling half-cycle, write the register in mid-access and hold the request high with altered attributes. These show that the wait pin is sampled only at a beat's last half-cycle and that the copied configuration and request stay fixed.

// File: rtl/csbt_pkg.sv
package csbt_pkg;

  localparam int REG_W   = 32;
  localparam int AW_W    = 3;
  localparam int IGN_BIT = 0;
  localparam int SW_LSB  = 2;
  localparam int AW_LSB  = 4;
  localparam int BW_LSB  = 8;
  localparam int CNT_W   = $clog2(2 * (1 << AW_W));

  typedef struct packed {
    logic [1:0]      bw;
    logic [AW_W-1:0] aw;
    logic [1:0]      sw;
    logic            ign;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_GAP,
    ST_HOLD
  } st_e;

  function automatic logic [REG_W-1:0] pack_cfg(cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[IGN_BIT]         = c.ign;
    r[SW_LSB +: 2]     = c.sw;
    r[AW_LSB +: AW_W]  = c.aw;
    r[BW_LSB +: 2]     = c.bw;
    return r;
  endfunction

  function automatic cfg_t unpack_cfg(logic [REG_W-1:0] r);
    cfg_t c;
    c.ign = r[IGN_BIT];
    c.sw  = r[SW_LSB +: 2];
    c.aw  = r[AW_LSB +: AW_W];
    c.bw  = r[BW_LSB +: 2];
    return c;
  endfunction

  localparam logic [REG_W-1:0] CFG_MASK = pack_cfg('1);

  // Setup lasts 2*sw+1 half-cycles; counter value loaded is that minus one.
  function automatic logic [CNT_W-1:0] setup_last(logic [1:0] sw);
    return CNT_W'({sw, 1'b0});
  endfunction

  // A strobe with w waits lasts 2*(w+1) half-cycles; loaded value is minus one.
  function automatic logic [CNT_W-1:0] strobe_last(logic [AW_W-1:0] w);
    return CNT_W'({w, 1'b1});
  endfunction

endpackage

// File: rtl/csbt_cfg_reg.sv
module csbt_cfg_reg
  import csbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rdata_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= unpack_cfg(wdata);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = pack_cfg(cfg_q);

  assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata_o == ($past(wdata) & CFG_MASK)));

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~CFG_MASK) == '0);

endmodule

// File: rtl/csbt_seq.sv
module csbt_seq
  import csbt_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int BE_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg_i,
  input  logic            req_i,
  input  logic            req_write_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [BE_W-1:0] req_be_i,
  input  logic            ext_wait_i,
  output st_e             st_o,
  output logic            write_o,
  output logic [BE_W-1:0] be_o,
  output logic            done_o,
  output logic            accept_o,
  output logic            beat_end_o
);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] beats_left_q;
  cfg_t             snap_q;
  logic             write_q;
  logic [BE_W-1:0]  be_q;
  logic             done_q;

  logic at_last, honour, extend, accept, beat_end;

  always_comb begin
    at_last  = (cnt_q == '0);
    honour   = !snap_q.ign;
    accept   = (st_q == ST_IDLE) && req_i;
    extend   = (st_q == ST_STROBE) && at_last && honour && ext_wait_i;
    beat_end = (st_q == ST_STROBE) && at_last && !extend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      beats_left_q <= '0;
      snap_q       <= '0;
      write_q      <= 1'b0;
      be_q         <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= beat_end;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            snap_q       <= cfg_i;
            write_q      <= req_write_i;
            be_q         <= req_be_i;
            beats_left_q <= req_len_i;
            cnt_q        <= setup_last(cfg_i.sw);
            st_q         <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (at_last) begin
            st_q  <= ST_STROBE;
            cnt_q <= strobe_last(snap_q.aw);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STROBE: begin
          if (extend) begin
            cnt_q <= CNT_W'(1);
          end else if (at_last) begin
            st_q <= (beats_left_q != '0) ? ST_GAP : ST_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_GAP: begin
          st_q         <= ST_STROBE;
          cnt_q        <= strobe_last(AW_W'(snap_q.bw));
          beats_left_q <= beats_left_q - 1'b1;
        end
        ST_HOLD: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign write_o    = write_q;
  assign be_o       = be_q;
  assign done_o     = done_q;
  assign accept_o   = accept;
  assign beat_end_o = beat_end;

  assert_setup_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP) |-> (cnt_q <= setup_last(snap_q.sw)));

  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(snap_q));

  assert_attr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(write_q) && $stable(be_q)));

  assert_extend_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    extend |=> (st_q == ST_STROBE && cnt_q == CNT_W'(1)));

  assert_mask_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STROBE && at_last && snap_q.ign) |=> (st_q != ST_STROBE));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/csbt_pins.sv
module csbt_pins
  import csbt_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  st_e             st_i,
  input  logic            write_i,
  input  logic [BE_W-1:0] be_i,
  output logic            cs_o,
  output logic            rd_o,
  output logic [BE_W-1:0] we_o
);

  logic strobe_phase;
  logic strobe_any;

  always_comb begin
    strobe_phase = (st_i == ST_STROBE);
    cs_o         = (st_i != ST_IDLE);
    rd_o         = strobe_phase && !write_i;
    we_o         = (strobe_phase && write_i) ? be_i : '0;
    strobe_any   = rd_o || (|we_o);
  end

  assert_cs_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> cs_o);

  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_any) |-> $past(cs_o));

  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && (|we_o)));

endmodule

// File: rtl/cs_bus_timing.sv
module cs_bus_timing
  import csbt_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int BE_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             req_i,
  input  logic             req_write_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [BE_W-1:0]  req_be_i,
  input  logic             ext_wait_i,
  output logic             cs_o,
  output logic             rd_o,
  output logic [BE_W-1:0]  we_o,
  output logic             done_o,
  output logic             busy_o
);

  cfg_t            cfg;
  st_e             st;
  logic            write_s;
  logic [BE_W-1:0] be_s;
  logic            accept;
  logic            beat_end;

  csbt_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_i),
    .wdata   (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  csbt_seq #(.LEN_W(LEN_W), .BE_W(BE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg),
    .req_i       (req_i),
    .req_write_i (req_write_i),
    .req_len_i   (req_len_i),
    .req_be_i    (req_be_i),
    .ext_wait_i  (ext_wait_i),
    .st_o        (st),
    .write_o     (write_s),
    .be_o        (be_s),
    .done_o      (done_o),
    .accept_o    (accept),
    .beat_end_o  (beat_end)
  );

  csbt_pins #(.BE_W(BE_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_i    (st),
    .write_i (write_s),
    .be_i    (be_s),
    .cs_o    (cs_o),
    .rd_o    (rd_o),
    .we_o    (we_o)
  );

  assign busy_o = (st != ST_IDLE);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && cs_o));

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |=> done_o);

endmodule

// File: tb/test_cs_bus_timing.sv
module test_cs_bus_timing;

  localparam int LEN_W = 3;
  localparam int BE_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr_i = 1'b0;
  logic [31:0]      cfg_wdata_i = '0;
  logic [31:0]      cfg_rdata_o;
  logic             req_i = 1'b0;
  logic             req_write_i = 1'b0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic [BE_W-1:0]  req_be_i = '0;
  logic             ext_wait_i = 1'b0;
  logic             cs_o, rd_o, done_o, busy_o;
  logic [BE_W-1:0]  we_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cs_bus_timing #(.LEN_W(LEN_W), .BE_W(BE_W)) i_cs_bus_timing (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .req_i(req_i), .req_write_i(req_write_i),
    .req_len_i(req_len_i), .req_be_i(req_be_i), .ext_wait_i(ext_wait_i),
    .cs_o(cs_o), .rd_o(rd_o), .we_o(we_o), .done_o(done_o), .busy_o(busy_o)
  );

  // Expected register image: ignore bit 0, setup 3:2, first wait 6:4, burst wait 9:8.
  function automatic logic [31:0] reg_image(int ign, int sw, int aw, int bw);
    return (32'(bw & 3) << 8) | (32'(aw & 7) << 4) | (32'(sw & 3) << 2) | 32'(ign & 1);
  endfunction

  function automatic logic [7:0] pins(bit cs, bit rd, logic [3:0] we, bit dn, bit bz);
    return {cs, rd, we, dn, bz};
  endfunction

  task automatic tick_check(input string tg, input logic [7:0] exp);
    logic [7:0] act;
    act = {cs_o, rd_o, we_o, done_o, busy_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: pins act=%b exp=%b", tg, $time, act, exp);
    end
  endtask

  task automatic write_cfg(input int ign, input int sw, input int aw, input int bw);
    logic [31:0] junk;
    junk = $urandom() & ~32'h0000_037D;
    @(negedge clk);
    cfg_wr_i    = 1'b1;
    cfg_wdata_i = reg_image(ign, sw, aw, bw) | junk;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    n_chk++;
    if (cfg_rdata_o !== reg_image(ign, sw, aw, bw)) begin
      n_fail++;
      $display("FAIL R2 readback act=%h exp=%h", cfg_rdata_o, reg_image(ign, sw, aw, bw));
    end
  endtask

  task automatic run_access(input int sw, input int aw, input int bw, input int ign,
                            input bit wr, input int beats, input logic [3:0] be,
                            input int ext_n, input bit mid_cfg, input bit hold_req);
    logic [3:0] exp_we;
    string tg;
    exp_we = wr ? be : 4'h0;
    @(negedge clk);
    req_i       = 1'b1;
    req_write_i = wr;
    req_len_i   = LEN_W'(beats - 1);
    req_be_i    = be;
    ext_wait_i  = 1'b0;
    @(negedge clk);
    if (!hold_req) req_i = 1'b0;
    else begin
      req_write_i = ~wr;
      req_be_i    = ~be;
      req_len_i   = LEN_W'($urandom());
    end
    // setup phase
    for (int i = 0; i < 2 * sw + 1; i++) begin
      tg = mid_cfg ? "R9" : (hold_req ? "R10" : "R3");
      tick_check(tg, pins(1, 0, 4'h0, 0, 1));
      cfg_wr_i = 1'b0;
      if (mid_cfg && i == 0) begin
        cfg_wr_i    = 1'b1;
        cfg_wdata_i = $urandom();
      end
      ext_wait_i = 1'($urandom() % 2);
      @(negedge clk);
    end
    cfg_wr_i = 1'b0;
    for (int b = 0; b < beats; b++) begin
      int len_h, ex, tot;
      len_h = (b == 0) ? 2 * (aw + 1) : 2 * (bw + 1);
      ex    = ign ? 0 : ext_n;
      tot   = len_h + 2 * ex;
      for (int i = 0; i < tot; i++) begin
        bit sampling;
        if (mid_cfg) tg = "R9";
        else if (hold_req) tg = "R10";
        else if (i >= len_h) tg = "R6";
        else if (ign != 0) tg = "R7";
        else tg = (b == 0) ? "R4" : "R5";
        tick_check(tg, pins(1, !wr, exp_we, 0, 1));
        sampling = (i >= len_h - 1) && (((i - (len_h - 1)) % 2) == 0);
        if (sampling) begin
          if (ign != 0) ext_wait_i = 1'b1;
          else ext_wait_i = (((i - (len_h - 1)) / 2) < ex);
        end else begin
          ext_wait_i = 1'($urandom() % 2);
        end
        @(negedge clk);
      end
      tick_check((b == beats - 1) ? "R8" : "R5", pins(1, 0, 4'h0, 1, 1));
      ext_wait_i = 1'($urandom() % 2);
      if (b == beats - 1) req_i = 1'b0;
      @(negedge clk);
    end
    tick_check(hold_req ? "R10" : "R8", pins(0, 0, 4'h0, 0, 0));
    ext_wait_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    tick_check("R1", pins(0, 0, 4'h0, 0, 0));
    n_chk++;
    if (cfg_rdata_o !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 cfg after reset act=%h exp=%h", cfg_rdata_o, 32'h0);
    end
    // R2: reserved bits only
    write_cfg(0, 0, 0, 0);
    // directed sweep over setup, burst wait and mask
    for (int sw = 0; sw < 4; sw++)
      for (int bw = 0; bw < 4; bw++)
        for (int ign = 0; ign < 2; ign++) begin
          int aw;
          aw = (sw + 2 * bw) % 8;
          write_cfg(ign, sw, aw, bw);
          run_access(sw, aw, bw, ign, bit'((sw + bw) % 2), 3, 4'hF >> (bw % 4),
                     1 + (sw % 2), 1'b0, 1'b0);
        end
    // R7 / R6 with zero first-beat waits
    write_cfg(1, 0, 0, 0);
    run_access(0, 0, 0, 1, 1'b0, 1, 4'h1, 2, 1'b0, 1'b0);
    write_cfg(0, 0, 0, 0);
    run_access(0, 0, 0, 0, 1'b1, 2, 4'h5, 2, 1'b0, 1'b0);
    // max wait and max beats
    write_cfg(0, 3, 7, 3);
    run_access(3, 7, 3, 0, 1'b1, 8, 4'hA, 1, 1'b0, 1'b0);
    // R9 and R10 directed
    write_cfg(0, 1, 2, 1);
    run_access(1, 2, 1, 0, 1'b0, 2, 4'h3, 1, 1'b1, 1'b0);
    write_cfg(1, 2, 1, 2);
    run_access(2, 1, 2, 1, 1'b1, 2, 4'h6, 0, 1'b0, 1'b1);
    // constrained random
    for (int n = 0; n < 60; n++) begin
      int sw, aw, bw, ign, beats, exn;
      sw    = int'($urandom() % 4);
      aw    = int'($urandom() % 8);
      bw    = int'($urandom() % 4);
      ign   = int'($urandom() % 2);
      beats = 1 + int'($urandom() % 4);
      exn   = int'($urandom() % 3);
      write_cfg(ign, sw, aw, bw);
      run_access(sw, aw, bw, ign, bit'($urandom() % 2), beats,
                 4'(1 + $urandom() % 15), exn, bit'($urandom() % 2), bit'($urandom() % 2));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule